// File: doc/BRIEF.md
# Memory Attribute Range Resolver

This block takes a physical address range, given as a start address and an exclusive end address, and returns the effective 8-bit memory type for it. It keeps its own copy of the attribute configuration. That copy holds a global default-type word with two enable bits and a flag saying fixed ranges exist, 88 fixed-range type bytes that tile the first 1 MiB, a parameterised number of variable base/mask entries, and an optional top-of-memory boundary. Software-side logic fills the copy through a simple write-only load port.

A lookup begins with a one-cycle `req_start` pulse. In the next cycle the block settles the cases that need no scan: an unconfigured or disabled unit, an address in the fixed-range window, or a disabled variable set. Otherwise it walks the variable entries, one per clock. It stops early when the range straddles an entry edge or when overlapping entries force the uncached type. After the last entry it applies the high-memory write-back override or falls back to the default type. `done` pulses for one cycle and `mem_type` holds the answer until the next accepted request.

Top module: `mar_resolver`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `mem_type` is 0xFF.
- R2: If the default-type word (load address 0x00) has never been written, or if both of its enable bits (data bits 8 and 9) are 0, the result is 0xFF.
- R3: If the fixed-ranges flag (data bit 10 of address 0x00) is set and start < 0x100000, the result is a fixed byte selected by start alone. The index is start>>16 below 0x80000, 8+((start−0x80000)>>14) from 0x80000 to 0xBFFFF, and 24+((start−0xC0000)>>12) from 0xC0000 up. Byte k of fixed word w (address 0x10+w, byte k at data bits 8k+7:8k) is entry 8w+k.
- R4: If the variable enable bit (data bit 9 of address 0x00) is 0 and R2 and R3 do not apply, the result is the default type (data bits 7:0 of address 0x00).
- R5: Variable entry i has a base word at address 0x20+2i and a mask word at 0x21+2i. The entry type is base bits 7:0, the entry takes part only when mask bit 11 is set, and bits 11:0 of both words are ignored for matching. An address A matches when (A & mask) == (base & mask). The end address is decremented by one before any comparison.
- R6: If any taking-part entry matches the start address but not the decremented end, or the reverse, the result is 0xFE and the scan stops at that entry.
- R7: Matching entries combine in index order. Uncached (0) with any type stops with uncached. Write-back (6) with write-through (4) gives write-through and the scan continues. Any other pair of differing types stops with uncached. Equal types keep that type. The other encodings are write-combining 1 and write-protect 5.
- R8: If the scan reaches its end, the boundary word (address 0x01, bits 39:0) is non-zero, start ≥ 2^32 and the decremented end is below the boundary, the result is write-back (6).
- R9: If the scan reaches its end with no matching entry and R8 does not apply, the result is the default type.
- R10: `done` is high for exactly one cycle per accepted request. `mem_type` stays unchanged until the next accepted request. A `req_start` while `busy` is high is ignored.
- R11: Counting edges from the edge that samples `req_start`, `done` is high after edge 1 when R2, R3 or R4 decide the result. When the scan stops at entry k it is high after edge k+2. A full scan puts it high after edge NVAR+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration word address |
| cfg_data | input | 64 | Configuration write data |
| req_start | input | 1 | Lookup request pulse |
| req_lo | input | ADDR_W | Range start address |
| req_hi | input | ADDR_W | Range end address, exclusive |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle result strobe |
| mem_type | output | 8 | Resolved memory type or error code |

## Verification
An early decision is due one edge after the sampling edge. A scan that stops at entry k is due after k+2 edges, and a full scan after NVAR+1 edges. Each table vector carries its expected count next to its expected type. The bench drives inputs on falling edges and, after each request, counts falling edges until it sees `done`. It checks the count and the type at that falling edge, so both a wrong answer and an answer in the wrong cycle are reported. The ignored-request and hold tests then watch further falling edges. No second strobe may appear, and the type must not move.

// File: rtl/mar_pkg.sv
package mar_pkg;
  localparam int PAGE_LSB  = 12;
  localparam int FIX_N     = 88;
  localparam int FIX_WORDS = FIX_N / 8;
  localparam int CFG_AW    = 8;
  localparam int CFG_DW    = 64;

  localparam logic [CFG_AW-1:0] A_DEF  = 8'h00;
  localparam logic [CFG_AW-1:0] A_TOP  = 8'h01;
  localparam logic [CFG_AW-1:0] A_FIX  = 8'h10;
  localparam logic [CFG_AW-1:0] A_VAR  = 8'h20;

  localparam logic [7:0] MT_UC   = 8'h00;
  localparam logic [7:0] MT_WC   = 8'h01;
  localparam logic [7:0] MT_WT   = 8'h04;
  localparam logic [7:0] MT_WP   = 8'h05;
  localparam logic [7:0] MT_WB   = 8'h06;
  localparam logic [7:0] MT_PART = 8'hFE;
  localparam logic [7:0] MT_OFF  = 8'hFF;

  typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_SCAN} scan_st_t;

  typedef struct packed {
    logic       stop;
    logic [7:0] ty;
  } merge_t;

  // Combine two matching entry types by precedence.
  function automatic merge_t merge_types(input logic [7:0] prev, input logic [7:0] curr);
    merge_t m;
    if (prev == MT_UC || curr == MT_UC) begin
      m = '{stop: 1'b1, ty: MT_UC};
    end else if ((prev == MT_WB && curr == MT_WT) || (prev == MT_WT && curr == MT_WB)) begin
      m = '{stop: 1'b0, ty: MT_WT};
    end else if (prev != curr) begin
      m = '{stop: 1'b1, ty: MT_UC};
    end else begin
      m = '{stop: 1'b0, ty: prev};
    end
    return m;
  endfunction
endpackage

// File: rtl/mar_cfg_regs.sv
module mar_cfg_regs
  import mar_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int NVAR   = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cfg_we,
  input  logic [CFG_AW-1:0]                    cfg_addr,
  input  logic [CFG_DW-1:0]                    cfg_data,
  output logic                                 loaded,
  output logic [7:0]                           def_type,
  output logic [1:0]                           en,
  output logic                                 has_fixed,
  output logic [ADDR_W-1:0]                    top_mem,
  output logic [FIX_N-1:0][7:0]                fix_bytes,
  output logic [NVAR-1:0][ADDR_W-PAGE_LSB-1:0] vbase,
  output logic [NVAR-1:0][ADDR_W-PAGE_LSB-1:0] vmask,
  output logic [NVAR-1:0][7:0]                 vtype,
  output logic [NVAR-1:0]                      vvalid
);
  localparam int PG_W = ADDR_W - PAGE_LSB;

  logic        we_def, we_top;
  logic        loaded_q;
  logic [10:0] def_q;
  logic [ADDR_W-1:0] top_q;
  logic [FIX_WORDS-1:0][CFG_DW-1:0] fix_q;

  assign we_def = cfg_we && (cfg_addr == A_DEF);
  assign we_top = cfg_we && (cfg_addr == A_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      def_q    <= '0;
    end else if (we_def) begin
      loaded_q <= 1'b1;
      def_q    <= cfg_data[10:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      top_q <= '0;
    else if (we_top) top_q <= cfg_data[ADDR_W-1:0];
  end

  for (genvar w = 0; w < FIX_WORDS; w++) begin : g_fix
    logic we_w;
    assign we_w = cfg_we && (cfg_addr == CFG_AW'(int'(A_FIX) + w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    fix_q[w] <= '0;
      else if (we_w) fix_q[w] <= cfg_data;
    end
  end

  for (genvar i = 0; i < NVAR; i++) begin : g_var
    logic we_b, we_m;
    logic [PG_W-1:0] base_q, mask_q;
    logic [7:0]      type_q;
    logic            valid_q;
    assign we_b = cfg_we && (cfg_addr == CFG_AW'(int'(A_VAR) + 2*i));
    assign we_m = cfg_we && (cfg_addr == CFG_AW'(int'(A_VAR) + 2*i + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        type_q <= '0;
      end else if (we_b) begin
        base_q <= cfg_data[ADDR_W-1:PAGE_LSB];
        type_q <= cfg_data[7:0];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q  <= '0;
        valid_q <= 1'b0;
      end else if (we_m) begin
        mask_q  <= cfg_data[ADDR_W-1:PAGE_LSB];
        valid_q <= cfg_data[11];
      end
    end
    assign vbase[i]  = base_q;
    assign vmask[i]  = mask_q;
    assign vtype[i]  = type_q;
    assign vvalid[i] = valid_q;
  end

  assign loaded    = loaded_q;
  assign def_type  = def_q[7:0];
  assign en        = def_q[9:8];
  assign has_fixed = def_q[10];
  assign top_mem   = top_q;
  assign fix_bytes = fix_q;

  // R2: once configured, the unit never reverts to unconfigured
  p_loaded_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |=> loaded);
endmodule

// File: rtl/mar_fixed_index.sv
module mar_fixed_index #(
  parameter int ADDR_W = 40
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_fixed,
  output logic [6:0]        idx
);
  assign in_fixed = (addr[ADDR_W-1:20] == '0);

  always_comb begin
    if (!addr[19])      idx = {4'd0, addr[18:16]};
    else if (!addr[18]) idx = 7'd8 + {3'd0, addr[17:14]};
    else                idx = 7'd24 + {1'b0, addr[17:12]};
  end
endmodule

// File: rtl/mar_scan_ctrl.sv
module mar_scan_ctrl
  import mar_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int NVAR   = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 req_start,
  input  logic [ADDR_W-1:0]                    req_lo,
  input  logic [ADDR_W-1:0]                    req_hi,
  input  logic                                 loaded,
  input  logic [7:0]                           def_type,
  input  logic [1:0]                           en,
  input  logic                                 has_fixed,
  input  logic [ADDR_W-1:0]                    top_mem,
  input  logic                                 fix_in,
  input  logic [7:0]                           fix_type,
  input  logic [NVAR-1:0][ADDR_W-PAGE_LSB-1:0] vbase,
  input  logic [NVAR-1:0][ADDR_W-PAGE_LSB-1:0] vmask,
  input  logic [NVAR-1:0][7:0]                 vtype,
  input  logic [NVAR-1:0]                      vvalid,
  output logic [ADDR_W-1:0]                    cap_lo,
  output logic                                 busy,
  output logic                                 done,
  output logic [7:0]                           result
);
  localparam int PG_W  = ADDR_W - PAGE_LSB;
  localparam int IDX_W = (NVAR > 1) ? $clog2(NVAR) : 1;

  scan_st_t          st_q, st_n;
  logic [ADDR_W-1:0] lo_q, lo_n, hi_q, hi_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic              hp_q, hp_n;
  logic [7:0]        pv_q, pv_n;
  logic [7:0]        res_q, res_n;
  logic              done_q, done_n;

  logic [PG_W-1:0] e_base, e_mask;
  logic            m_lo, m_hi, fin, top_hit;
  merge_t          mg;

  assign e_base  = vbase[idx_q];
  assign e_mask  = vmask[idx_q];
  assign m_lo    = ((lo_q[ADDR_W-1:PAGE_LSB] & e_mask) == (e_base & e_mask));
  assign m_hi    = ((hi_q[ADDR_W-1:PAGE_LSB] & e_mask) == (e_base & e_mask));
  assign mg      = merge_types(pv_q, vtype[idx_q]);
  assign top_hit = (top_mem != '0) && (lo_q[ADDR_W-1:32] != '0) && (hi_q < top_mem);

  always_comb begin
    st_n   = st_q;
    lo_n   = lo_q;
    hi_n   = hi_q;
    idx_n  = idx_q;
    hp_n   = hp_q;
    pv_n   = pv_q;
    res_n  = res_q;
    done_n = 1'b0;
    fin    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_start) begin
          lo_n = req_lo;
          hi_n = req_hi - 1'b1;
          st_n = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (!loaded || en == 2'b00) begin
          res_n = MT_OFF;
          fin   = 1'b1;
        end else if (has_fixed && fix_in) begin
          res_n = fix_type;
          fin   = 1'b1;
        end else if (!en[1]) begin
          res_n = def_type;
          fin   = 1'b1;
        end else begin
          st_n  = ST_SCAN;
          idx_n = '0;
          hp_n  = 1'b0;
        end
      end
      ST_SCAN: begin
        if (vvalid[idx_q] && (m_lo != m_hi)) begin
          res_n = MT_PART;
          fin   = 1'b1;
        end else if (vvalid[idx_q] && m_lo) begin
          if (!hp_q) begin
            hp_n = 1'b1;
            pv_n = vtype[idx_q];
          end else if (mg.stop) begin
            res_n = mg.ty;
            fin   = 1'b1;
          end else begin
            pv_n = mg.ty;
          end
        end
        if (!fin) begin
          if (idx_q == IDX_W'(NVAR - 1)) begin
            fin = 1'b1;
            if (top_hit)   res_n = MT_WB;
            else if (hp_n) res_n = pv_n;
            else           res_n = def_type;
          end else begin
            idx_n = idx_q + 1'b1;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (fin) begin
      done_n = 1'b1;
      st_n   = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      lo_q   <= '0;
      hi_q   <= '0;
      idx_q  <= '0;
      hp_q   <= 1'b0;
      pv_q   <= '0;
      res_q  <= MT_OFF;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      lo_q   <= lo_n;
      hi_q   <= hi_n;
      idx_q  <= idx_n;
      hp_q   <= hp_n;
      pv_q   <= pv_n;
      res_q  <= res_n;
      done_q <= done_n;
    end
  end

  assign cap_lo = lo_q;
  assign busy   = (st_q != ST_IDLE);
  assign done   = done_q;
  assign result = res_q;

  // R10: the strobe lasts one cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: the strobe comes with the controller back in idle
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R10: the result only moves together with the strobe
  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(res_q));
  // R10: a request during a lookup leaves the captured range alone
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_start) |=> $stable(lo_q));
  // R2: an unconfigured unit reports the disabled code
  p_unloaded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(loaded)) |-> (res_q == MT_OFF));
  // R6: a partial-cover code needs the variable set enabled
  p_part_var_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_q == MT_PART) |-> en[1]);
  // R11: the scan index stays inside the entry set
  p_idx_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SCAN) |-> (int'(idx_q) < NVAR));
endmodule

// File: rtl/mar_resolver.sv
module mar_resolver
  import mar_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int NVAR   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [63:0]       cfg_data,
  input  logic              req_start,
  input  logic [ADDR_W-1:0] req_lo,
  input  logic [ADDR_W-1:0] req_hi,
  output logic              busy,
  output logic              done,
  output logic [7:0]        mem_type
);
  localparam int PG_W = ADDR_W - PAGE_LSB;

  logic                      loaded, has_fixed, fix_in;
  logic [7:0]                def_type, fix_type;
  logic [1:0]                en;
  logic [ADDR_W-1:0]         top_mem, cap_lo;
  logic [FIX_N-1:0][7:0]     fix_bytes;
  logic [NVAR-1:0][PG_W-1:0] vbase, vmask;
  logic [NVAR-1:0][7:0]      vtype;
  logic [NVAR-1:0]           vvalid;
  logic [6:0]                fix_idx;

  mar_cfg_regs #(.ADDR_W(ADDR_W), .NVAR(NVAR)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .loaded(loaded), .def_type(def_type), .en(en), .has_fixed(has_fixed),
    .top_mem(top_mem), .fix_bytes(fix_bytes), .vbase(vbase), .vmask(vmask),
    .vtype(vtype), .vvalid(vvalid)
  );

  mar_fixed_index #(.ADDR_W(ADDR_W)) u_fix (
    .addr(cap_lo), .in_fixed(fix_in), .idx(fix_idx)
  );

  assign fix_type = fix_bytes[fix_idx];

  mar_scan_ctrl #(.ADDR_W(ADDR_W), .NVAR(NVAR)) u_scan (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_lo(req_lo), .req_hi(req_hi),
    .loaded(loaded), .def_type(def_type), .en(en), .has_fixed(has_fixed),
    .top_mem(top_mem), .fix_in(fix_in), .fix_type(fix_type), .vbase(vbase),
    .vmask(vmask), .vtype(vtype), .vvalid(vvalid), .cap_lo(cap_lo),
    .busy(busy), .done(done), .result(mem_type)
  );
endmodule

// File: tb/mar_resolver_tb.sv
module mar_resolver_tb;
  localparam int AW = 40;
  localparam int NV = 8;

  typedef struct packed {
    logic [39:0] lo;
    logic [39:0] hi;
    logic [7:0]  ty;
    logic [7:0]  lat;
    logic [7:0]  rq;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{40'h00000, 40'h01000, 8'd0,  8'd1, 8'd3},    // R3 64 KiB granule 0
    '{40'h70000, 40'h71000, 8'd7,  8'd1, 8'd3},    // R3 granule 7
    '{40'h80000, 40'h81000, 8'd8,  8'd1, 8'd3},    // R3 16 KiB first
    '{40'hBC000, 40'hBD000, 8'd23, 8'd1, 8'd3},    // R3 16 KiB last
    '{40'hC0000, 40'hC1000, 8'd24, 8'd1, 8'd3},    // R3 4 KiB first
    '{40'hFF000, 40'h100000, 8'd87, 8'd1, 8'd3},   // R3 4 KiB last
    '{40'h10000000, 40'h10001000, 8'h06, 8'd9, 8'd5},   // R5 single write-back
    '{40'h18000000, 40'h18001000, 8'h04, 8'd9, 8'd7},   // R7 WB with WT
    '{40'h20000000, 40'h20001000, 8'h00, 8'd5, 8'd7},   // R7 UC stops at entry 3
    '{40'h20100000, 40'h20101000, 8'h01, 8'd9, 8'd5},   // R5 only entry 3
    '{40'h200FF000, 40'h20101000, 8'hFE, 8'd4, 8'd6},   // R6 straddle at entry 2
    '{40'h40000000, 40'h40001000, 8'h00, 8'd7, 8'd7},   // R7 WC vs WP
    '{40'h50000000, 40'h50001000, 8'h05, 8'd9, 8'd5},   // R5 invalid entry skipped
    '{40'h60000000, 40'h60001000, 8'h06, 8'd9, 8'd5},   // R5 exclusive end
    '{40'h100000000, 40'h100001000, 8'h06, 8'd9, 8'd8}, // R8 override
    '{40'h200000000, 40'h200001000, 8'h05, 8'd9, 8'd8}, // R8 end at boundary
    '{40'h30000000, 40'h30001000, 8'h05, 8'd9, 8'd9}    // R9 no match
  };

  logic        clk, rst_n, cfg_we, req_start;
  logic [7:0]  cfg_addr;
  logic [63:0] cfg_data;
  logic [AW-1:0] req_lo, req_hi;
  logic        busy, done;
  logic [7:0]  mem_type;
  int checks, errors;
  bit finished;

  mar_resolver #(.ADDR_W(AW), .NVAR(NV)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .req_start(req_start), .req_lo(req_lo), .req_hi(req_hi),
    .busy(busy), .done(done), .mem_type(mem_type)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input int rq, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_def(input logic [7:0] ty, input logic fen, input logic ven, input logic hf);
    cfg_wr(8'h00, {53'd0, hf, ven, fen, ty});
  endtask

  task automatic set_var(input int i, input logic [39:0] b, input logic [39:0] m,
                         input logic [7:0] ty, input logic v);
    cfg_wr(8'(32 + 2*i), {24'd0, b[39:12], 4'hA, ty});
    cfg_wr(8'(33 + 2*i), {24'd0, m[39:12], v, 11'h3FF});
  endtask

  task automatic run(input logic [39:0] lo, input logic [39:0] hi, input logic [7:0] ety,
                     input int elat, input int rq);
    int lat;
    @(negedge clk);
    req_lo = lo; req_hi = hi; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    lat = 0;
    while (lat < 40) begin
      @(negedge clk);
      lat++;
      if (done) break;
    end
    chk(lat == elat, rq, "latency", lat, elat);
    chk(mem_type == ety, rq, "type", mem_type, ety);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; finished = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
    req_start = 1'b0; req_lo = '0; req_hi = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, 1, "busy", busy, 0);
    chk(done == 1'b0, 1, "done", done, 0);
    chk(mem_type == 8'hFF, 1, "type", mem_type, 8'hFF);

    // R2 never configured, then both enables clear
    run(40'h10000000, 40'h10001000, 8'hFF, 1, 2);
    set_def(8'h05, 1'b0, 1'b0, 1'b1);
    run(40'h00000, 40'h01000, 8'hFF, 1, 2);

    // R11 configuration through the load port
    for (int w = 0; w < 11; w++) begin
      logic [63:0] d;
      for (int k = 0; k < 8; k++) d[8*k +: 8] = 8'(8*w + k);
      cfg_wr(8'(16 + w), d);
    end
    set_var(0, 40'h10000000, 40'hFF0000000, 8'h06, 1'b1);
    set_var(1, 40'h18000000, 40'hFF8000000, 8'h04, 1'b1);
    set_var(2, 40'h20000000, 40'hFFFF00000, 8'h00, 1'b1);
    set_var(3, 40'h20000000, 40'hFFF000000, 8'h01, 1'b1);
    set_var(4, 40'h40000000, 40'hFFFF00000, 8'h01, 1'b1);
    set_var(5, 40'h40000000, 40'hFFFF00000, 8'h05, 1'b1);
    set_var(6, 40'h50000000, 40'hFF0000000, 8'h00, 1'b0);
    set_var(7, 40'h60000000, 40'hFFFFFF000, 8'h06, 1'b1);
    cfg_wr(8'h01, 64'h200000000);
    set_def(8'h05, 1'b1, 1'b1, 1'b1);

    // table walk covering R3 R5 R6 R7 R8 R9 and R11 timing
    for (int v = 0; v < NVEC; v++)
      run(VECS[v].lo, VECS[v].hi, VECS[v].ty, int'(VECS[v].lat), int'(VECS[v].rq));

    // R4 variable set disabled: default, fixed window still served
    set_def(8'h05, 1'b1, 1'b0, 1'b1);
    run(40'h10000000, 40'h10001000, 8'h05, 1, 4);
    run(40'h70000, 40'h71000, 8'd7, 1, 4);
    // R3 fixed window served with only the variable enable set
    set_def(8'h05, 1'b0, 1'b1, 1'b1);
    run(40'hC1000, 40'hC2000, 8'd25, 1, 3);
    // R3 without fixed ranges the low address goes through the scan
    set_def(8'h05, 1'b1, 1'b1, 1'b0);
    run(40'h00000, 40'h01000, 8'h05, 9, 3);
    set_def(8'h05, 1'b1, 1'b1, 1'b1);
    // R8 zero boundary disables the override
    cfg_wr(8'h01, 64'h0);
    run(40'h100000000, 40'h100001000, 8'h05, 9, 8);

    // R10 request during a lookup is ignored; single strobe, held result
    begin
      int lat, strobes;
      @(negedge clk);
      req_lo = 40'h10000000; req_hi = 40'h10001000; req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
      lat = 0; strobes = 0;
      while (lat < 40) begin
        @(negedge clk);
        lat++;
        if (lat == 2) begin req_lo = 40'h0; req_hi = 40'h1000; req_start = 1'b1; end
        if (lat == 3) req_start = 1'b0;
        if (done) break;
      end
      chk(lat == 9, 10, "latency with ignored request", lat, 9);
      chk(mem_type == 8'h06, 10, "type with ignored request", mem_type, 8'h06);
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (done) strobes++;
      end
      chk(strobes == 0, 10, "extra strobes", strobes, 0);
      chk(mem_type == 8'h06, 10, "held type", mem_type, 8'h06);
      chk(busy == 1'b0, 10, "busy after hold", busy, 0);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule